// File: doc/BRIEF.md
# Byte-Granular FIFO Data Port

This block is the 32-bit data register that sits between a host bus and the byte-wide FIFO of a serial flash controller. A host access carries a size (byte, halfword or word). In the indirect write mode it moves that many bytes from the write data into the FIFO. In the indirect read mode it moves that many bytes out of the FIFO onto the read data. The shift engine on the other side moves one byte per cycle through its own push and pop strobes.

The host `reqReady` output stalls the bus when the FIFO cannot serve the whole access. A write waits for room. A read waits for data while the engine reports busy. The wait ends early when the transfer finishes, and the read then returns whatever bytes are left. In the automatic polling mode the port instead presents the last complete status word the engine delivered, and the FIFO is not touched. Level and free-space counts are exported so that the engine can throttle itself.

Top module: `byte_fifo_port`

## Requirements
- R1: Encodings: `mode` 2'b00 is indirect write, 2'b01 is indirect read, 2'b10 or 2'b11 is automatic polling. `reqSize` 2'b00 is a byte (1), 2'b01 a halfword (2), 2'b10 or 2'b11 a word (4). An accepted write in indirect write mode pushes 1, 2 or 4 bytes. The bytes are taken from `reqWdata[7:0]` first, then `[15:8]`, `[23:16]` and `[31:24]`, and the engine pops them in that order from `engPopData`.
- R2: An accepted read in indirect read mode pops 1, 2 or 4 bytes. The oldest byte appears on `rdData[7:0]` and the following bytes on the next lanes upward. The lanes above the access size read zero. `rdData` is valid in the cycle where `reqValid` and `reqReady` are both high.
- R3: In indirect write mode, a write whose size exceeds `fifoFree` is held with `reqReady` low, and it pushes nothing while held.
- R4: In indirect read mode, with `engBusy` high and `engDone` low, a read whose size exceeds `fifoLevel` is held with `reqReady` low and pops nothing. It is served once enough bytes are present.
- R5: In indirect read mode, with `engBusy` low, a read never stalls. If fewer bytes than its size are present, it returns them in the low lanes, zero-fills the rest and leaves the FIFO empty.
- R6: A pulse on `engDone` releases a read that is held while busy, in the same cycle and in the same way as R5.
- R7: `pollLoad` captures `pollWord`. In polling mode a read of any size is accepted at once, returns the captured word unmasked, and leaves `fifoLevel` unchanged.
- R8: After reset, the captured word is zero, `fifoLevel` is 0, `fifoFree` is DEPTH and `engErr` is low.
- R9: An engine push with no room left, or an engine pop with no byte left, is ignored. `engErr` is high for exactly the one cycle after the offending edge.
- R10: `fifoLevel` counts the bytes held, never exceeds DEPTH, and `fifoFree` always equals DEPTH minus `fifoLevel`.
- R11: A read in indirect write mode, or a write in indirect read mode, is accepted at once, has no effect on the FIFO, and a read of this kind returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode (see R1) |
| reqValid | input | 1 | Host access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access size (see R1) |
| reqWdata | input | 32 | Host write data |
| reqReady | output | 1 | Access completes this cycle; low stalls the bus |
| rdData | output | 32 | Host read data |
| engPush | input | 1 | Engine pushes one received byte |
| engPushData | input | 8 | Byte pushed by the engine |
| engPop | input | 1 | Engine pops one byte to transmit |
| engPopData | output | 8 | Oldest byte not taken by the host this cycle |
| engBusy | input | 1 | Serial transfer in progress |
| engDone | input | 1 | Transfer-complete pulse |
| pollLoad | input | 1 | Status word received |
| pollWord | input | 32 | Received status word |
| fifoLevel | output | LVLW | Bytes held |
| fifoFree | output | LVLW | Free byte slots |
| engErr | output | 1 | One-cycle flag for an ignored engine strobe |

## Verification
The bench builds the port with an 8-byte FIFO. With that depth every fill level from empty to full can be swept against every access size. The sweep covers each write-stall boundary, each read-stall boundary, and each short-read release by busy low and by the done pulse. It also reaches the full and empty states, so overflow and underflow of engine strobes can be provoked within a few cycles.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  localparam logic [1:0] MODE_WR = 2'b00;
  localparam logic [1:0] MODE_RD = 2'b01;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic [2:0] pushN;     // host bytes pushed
    logic [2:0] popN;      // host bytes popped
    logic       engPushOk; // engine push accepted
    logic       engPopOk;  // engine pop accepted
  } strobe_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bfp_ctrl.sv
module bfp_ctrl
  import bfp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      mode,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [1:0]      reqSize,
  input  logic [LVLW-1:0] level,
  input  logic            engPush,
  input  logic            engPop,
  input  logic            engBusy,
  input  logic            engDone,
  output logic            reqReady,
  output strobe_t         strb,
  output logic [LVLW-1:0] freeCnt,
  output logic            engErr
);

  logic [2:0] needN;
  logic       hostWr, hostRd, roomOk, dataOk, relOk;

  assign needN   = sizeBytes(reqSize);
  assign freeCnt = LVLW'(DEPTH) - level;
  assign hostWr  = reqValid && reqWrite && (mode == MODE_WR);
  assign hostRd  = reqValid && !reqWrite && (mode == MODE_RD);
  assign roomOk  = int'(freeCnt) >= int'(needN);
  assign dataOk  = int'(level) >= int'(needN);
  assign relOk   = dataOk || !engBusy || engDone;

  always_comb begin
    reqReady = 1'b1;
    strb     = '0;
    if (hostWr) begin
      reqReady = roomOk;
      if (roomOk) strb.pushN = needN;
    end else if (hostRd) begin
      reqReady = relOk;
      if (relOk) strb.popN = dataOk ? needN : 3'(level);
    end
    // engine strobes see what the host takes this cycle
    strb.engPushOk = engPush && (int'(level) + int'(strb.pushN) < DEPTH);
    strb.engPopOk  = engPop && (int'(level) > int'(strb.popN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) engErr <= 1'b0;
    else       engErr <= (engPush && !strb.engPushOk) || (engPop && !strb.engPopOk);
  end

  assert_write_room_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && mode == MODE_WR) |-> int'(freeCnt) >= int'(needN));

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && mode == MODE_RD && engBusy && !engDone &&
     int'(level) < int'(needN)) |-> !reqReady);

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    engErr |-> $past(engPush || engPop));

  assert_poll_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1] && !engPush && !engPop) |=> $stable(level));

endmodule

// File: rtl/bfp_data.sv
module bfp_data
  import bfp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVLW  = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      mode,
  input  strobe_t         strb,
  input  logic [31:0]     reqWdata,
  input  logic [7:0]      engPushData,
  input  logic            pollLoad,
  input  logic [31:0]     pollWord,
  output logic [LVLW-1:0] level,
  output logic [31:0]     rdData,
  output logic [7:0]      engPopData
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [31:0]   pollReg;
  logic [31:0]   laneData;

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (int'(strb.pushN) > i) mem[wrPtr + PW'(i)] <= reqWdata[8*i +: 8];
    end
    if (strb.engPushOk) mem[wrPtr + PW'(strb.pushN)] <= engPushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      pollReg <= '0;
    end else begin
      wrPtr <= wrPtr + PW'(strb.pushN) + PW'(strb.engPushOk);
      rdPtr <= rdPtr + PW'(strb.popN) + PW'(strb.engPopOk);
      level <= level + LVLW'(strb.pushN) + LVLW'(strb.engPushOk)
                     - LVLW'(strb.popN) - LVLW'(strb.engPopOk);
      if (pollLoad) pollReg <= pollWord;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign laneData[8*i +: 8] = (int'(strb.popN) > i) ? mem[rdPtr + PW'(i)] : 8'h00;
  end

  assign rdData     = mode[1] ? pollReg : (mode == MODE_RD) ? laneData : 32'h0;
  assign engPopData = mem[rdPtr + PW'(strb.popN)];

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    int'(level) <= DEPTH);

  assert_drain_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popN != 0 && int'(strb.popN) == int'(level) && !strb.engPushOk) |=> level == '0);

endmodule

// File: rtl/byte_fifo_port.sv
module byte_fifo_port
  import bfp_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      mode,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [1:0]      reqSize,
  input  logic [31:0]     reqWdata,
  output logic            reqReady,
  output logic [31:0]     rdData,
  input  logic            engPush,
  input  logic [7:0]      engPushData,
  input  logic            engPop,
  output logic [7:0]      engPopData,
  input  logic            engBusy,
  input  logic            engDone,
  input  logic            pollLoad,
  input  logic [31:0]     pollWord,
  output logic [LVLW-1:0] fifoLevel,
  output logic [LVLW-1:0] fifoFree,
  output logic            engErr
);

  strobe_t strb;

  bfp_ctrl #(.DEPTH(DEPTH), .LVLW(LVLW)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .level(fifoLevel), .engPush(engPush), .engPop(engPop),
    .engBusy(engBusy), .engDone(engDone), .reqReady(reqReady), .strb(strb),
    .freeCnt(fifoFree), .engErr(engErr)
  );

  bfp_data #(.DEPTH(DEPTH), .LVLW(LVLW)) u_data (
    .clk(clk), .rstN(rstN), .mode(mode), .strb(strb), .reqWdata(reqWdata),
    .engPushData(engPushData), .pollLoad(pollLoad), .pollWord(pollWord),
    .level(fifoLevel), .rdData(rdData), .engPopData(engPopData)
  );

endmodule

// File: tb/byte_fifo_port_tb.sv
module byte_fifo_port_tb;

  localparam int DEPTH = 8;
  localparam int LVLW  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'b10;
  logic reqValid = 0, reqWrite = 0;
  logic [1:0] reqSize = 0;
  logic [31:0] reqWdata = 0;
  logic reqReady;
  logic [31:0] rdData;
  logic engPush = 0, engPop = 0, engBusy = 0, engDone = 0, pollLoad = 0;
  logic [7:0] engPushData = 0;
  logic [7:0] engPopData;
  logic [31:0] pollWord = 0;
  logic [LVLW-1:0] fifoLevel, fifoFree;
  logic engErr;

  int nChk = 0, nFail = 0;
  logic [7:0] q[$];

  always #4 clk = ~clk;

  byte_fifo_port #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqWdata(reqWdata), .reqReady(reqReady), .rdData(rdData),
    .engPush(engPush), .engPushData(engPushData), .engPop(engPop), .engPopData(engPopData),
    .engBusy(engBusy), .engDone(engDone), .pollLoad(pollLoad), .pollWord(pollWord),
    .fifoLevel(fifoLevel), .fifoFree(fifoFree), .engErr(engErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkLevel(input string tag, input int exp);
    chk(tag, 32'(fifoLevel), 32'(exp));
    chk("R10 free", 32'(fifoFree), 32'(DEPTH - exp));
  endtask

  // engine push of one byte, model updated
  task automatic pushEng(input logic [7:0] b);
    engPush = 1; engPushData = b;
    @(negedge clk);
    engPush = 0;
    q.push_back(b);
  endtask

  task automatic popEng(input string tag);
    engPop = 1;
    #1 chk(tag, 32'(engPopData), 32'(q[0]));
    @(negedge clk);
    engPop = 0;
    void'(q.pop_front());
  endtask

  task automatic hostWrite(input logic [1:0] sz, input logic [31:0] d,
                           input logic expRdy, input string tag);
    int n;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    reqValid = 1; reqWrite = 1; reqSize = sz; reqWdata = d;
    #1 chk(tag, 32'(reqReady), 32'(expRdy));
    @(negedge clk);
    reqValid = 0;
    if (expRdy) for (int i = 0; i < n; i++) q.push_back(d[8*i +: 8]);
  endtask

  // read in RD mode: expected data computed from the model queue
  task automatic hostRead(input logic [1:0] sz, input logic expRdy, input string tag);
    int n, m;
    logic [31:0] exp;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    m = (q.size() < n) ? q.size() : n;
    exp = 0;
    for (int i = 0; i < m; i++) exp[8*i +: 8] = q[i];
    reqValid = 1; reqWrite = 0; reqSize = sz;
    #1 chk({tag, " ready"}, 32'(reqReady), 32'(expRdy));
    if (expRdy) chk({tag, " data"}, rdData, exp);
    @(negedge clk);
    reqValid = 0;
    if (expRdy) for (int i = 0; i < m; i++) void'(q.pop_front());
  endtask

  task automatic flush();
    mode = 2'b01; engBusy = 0;
    while (fifoLevel != 0) begin
      reqValid = 1; reqWrite = 0; reqSize = 2'b10;
      @(negedge clk);
      reqValid = 0;
    end
    q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R8 reset state
    chkLevel("R8 level", 0);
    chk("R8 err", 32'(engErr), 0);
    reqValid = 1; reqWrite = 0; reqSize = 2'b10;
    #1 chk("R8 poll word", rdData, 32'h0);
    @(negedge clk); reqValid = 0;

    // R1/R3 write sweep over every fill level and size
    for (int L = 0; L <= DEPTH; L++) begin
      for (int s = 0; s < 3; s++) begin
        int n;
        logic rdy;
        n = 1 << s;
        rdy = (DEPTH - L) >= n;
        flush();
        mode = 2'b00;
        for (int j = 0; j < L; j++) hostWrite(2'b00, 32'(8'h10 + j), 1'b1, "R1 fill");
        hostWrite(2'(s), 32'hA1B2C3D4 ^ 32'(L * 16 + s), rdy, "R3 write ready");
        chkLevel(rdy ? "R1 level after write" : "R3 level while held", rdy ? L + n : L);
        if (rdy) while (q.size() > 0) popEng("R1 lane order");
      end
    end

    // R2/R4/R5/R6 read sweep
    for (int k = 0; k <= DEPTH; k++) begin
      for (int s = 0; s < 3; s++) begin
        int n;
        logic rdy;
        n = 1 << s;
        rdy = k >= n;
        flush();
        for (int j = 0; j < k; j++) pushEng(8'(8'h40 + k * 8 + j));
        engBusy = 1;
        hostRead(2'(s), rdy, rdy ? "R2 read" : "R4 held read");
        chkLevel(rdy ? "R2 level after read" : "R4 level while held", rdy ? k - n : k);
        if (!rdy) begin
          if (((k + s) % 2) == 0) begin
            engBusy = 0;
            hostRead(2'(s), 1'b1, "R5 short read busy low");
            chkLevel("R5 emptied", 0);
          end else begin
            engDone = 1;
            hostRead(2'(s), 1'b1, "R6 short read on done");
            engDone = 0;
            chkLevel("R6 emptied", 0);
          end
        end
        engBusy = 0;
      end
    end

    // R4 held read served once bytes arrive
    flush(); engBusy = 1;
    pushEng(8'h11);
    hostRead(2'b01, 1'b0, "R4 held half");
    pushEng(8'h22);
    hostRead(2'b01, 1'b1, "R4 served half");
    engBusy = 0;

    // R9 pop from empty
    flush(); mode = 2'b00;
    engPop = 1; @(negedge clk); engPop = 0;
    chk("R9 err after pop empty", 32'(engErr), 1);
    chkLevel("R9 level after bad pop", 0);
    @(negedge clk);
    chk("R9 err one cycle", 32'(engErr), 0);

    // R9 push into full
    mode = 2'b01;
    for (int j = 0; j < DEPTH; j++) pushEng(8'(8'h70 + j));
    chk("R9 no err on good push", 32'(engErr), 0);
    engPush = 1; engPushData = 8'hEE; @(negedge clk); engPush = 0;
    chk("R9 err after push full", 32'(engErr), 1);
    chkLevel("R9 level after bad push", DEPTH);
    engBusy = 1;
    hostRead(2'b10, 1'b1, "R9 contents intact");
    engBusy = 0;

    // R11 mismatched direction
    flush(); mode = 2'b01;
    pushEng(8'h5A);
    hostWrite(2'b10, 32'hDEADBEEF, 1'b1, "R11 write in read mode");
    chkLevel("R11 level after write", 1);
    mode = 2'b00;
    reqValid = 1; reqWrite = 0; reqSize = 2'b10;
    #1 chk("R11 read ready", 32'(reqReady), 1);
    chk("R11 read data", rdData, 0);
    @(negedge clk); reqValid = 0;
    chkLevel("R11 level after read", 1);

    // R7 polling
    pollLoad = 1; pollWord = 32'hCAFE1234; @(negedge clk); pollLoad = 0;
    for (int m = 2; m < 4; m++) begin
      for (int s = 0; s < 3; s++) begin
        mode = 2'(m);
        reqValid = 1; reqWrite = 0; reqSize = 2'(s);
        #1 chk("R7 poll ready", 32'(reqReady), 1);
        chk("R7 poll data", rdData, 32'hCAFE1234);
        @(negedge clk); reqValid = 0;
        chkLevel("R7 level unchanged", 1);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule